// File: doc/BRIEF.md
# LED Trim Register Target with One-Time-Programmable Store

This block is a fixed-address two-wire serial target that holds two LED-current trim values: a 6-bit value for the switching string and a 4-bit value for the linear string. It also holds a control register that starts two timed operations on a small internal one-time-programmable (OTP) store. A reload copies the stored trims, and the stored "burned" marker, into the live registers. A burn freezes the current live trims into the store.

A power-on event on `por_i` starts a reload. So does setting the reload bit of the control register. While a reload runs, the block asks for its slow timebase through `osc_en_o` and counts `tick_i` pulses. A burn is armed by setting the burn bit, which raises `burn_en_o` as the request for the high programming supply. The burn is committed when software clears that bit, provided the bit was held long enough. The burned marker that software sees changes only on the next reload.

The serial side samples SCL and SDA through synchronizers on the system clock. It drives the bus only through an open-drain pull-down output.

Top module: `trim_otp_i2c`

## Requirements
- R1: After reset the switching trim output is 0x1F, the linear trim output is 0x07, the control register reads 0x08, and `osc_en_o`, `burn_en_o` and `sda_pull_o` are low.
- R2: The target answers only to 7-bit address 0x28. The first byte carries the address in bits 7:1 and the direction in bit 0, where 0 means write and 1 means read. Any other address gets no acknowledge, and the transaction has no effect.
- R3: A write is target address, register address, then data. The target acknowledges each byte by pulling SDA low during the 9th clock. The new value takes effect at the SCL rising edge of the acknowledge that follows the data byte.
- R4: A read is a write of the register address, then a repeated START, the target address with direction 1, and one byte returned MSB first. The master ends the read with a NACK and a STOP.
- R5: Register 0x01 holds the switching trim in bits 5:0. Register 0x02 holds the linear trim in bits 3:0. Writes to the upper bits are dropped, and those bits read 0.
- R6: Any register address other than 0x01, 0x02 and 0xFF reads 0x00. Writes to such an address change nothing.
- R7: A START or STOP that arrives before the acknowledge that follows the data byte abandons the write. The register keeps its old value.
- R8: Register 0xFF has these bits: bit 4 is the burned marker, bit 3 always reads 1, bit 2 is the burn bit and reads back as written, and bit 0 is the reload bit and always reads 0. All other bits read 0. `burn_en_o` follows the burn bit.
- R9: Writing 1 to bit 0 of 0xFF, or a pulse on `por_i`, raises `osc_en_o`. After RELOAD_TICKS ticks, both trims are loaded from the store and `osc_en_o` falls. A store that has never been burned gives 0x1F and 0x07.
- R10: `osc_en_o` is high while the burn bit is set. The store takes the live trims when the burn bit goes from 1 to 0, but only if the bit was held for at least BURN_TICKS ticks. A shorter hold stores nothing.
- R11: After a burn, the burned marker in 0xFF stays 0 until a reload completes. After that reload it reads 1.
- R12: Once burned, the store ignores every further burn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also returns the store to blank |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | Open-drain pull-down request for SDA |
| por_i | input | 1 | Power-on event pulse that starts a reload |
| tick_i | input | 1 | One-cycle enable from the 500 kHz timebase |
| sw_trim_o | output | SW_W | Live switching-string trim |
| lin_trim_o | output | LIN_W | Live linear-string trim |
| osc_en_o | output | 1 | Request for the slow timebase |
| burn_en_o | output | 1 | Programming-supply request, high while the burn bit is set |

## Verification
The assertions assume that SCL and SDA each stay steady for several system clocks, much longer than the synchronizer depth. They also assume that SDA changes while SCL is high only to signal START or STOP, and that `tick_i` is a one-cycle pulse spaced well apart. The stimulus meets these assumptions: every bus phase lasts sixteen clocks, the master changes SDA only during SCL low except at START and STOP, and the tick arrives once every four clocks. Burn hold times are set on either side of BURN_TICKS by a wide margin, so that synchronizer latency cannot decide the outcome.

// File: rtl/trim_otp_pkg.sv
package trim_otp_pkg;
  localparam logic [6:0] DEV_ADDR = 7'h28;
  localparam logic [7:0] ADDR_SW  = 8'h01;
  localparam logic [7:0] ADDR_LIN = 8'h02;
  localparam logic [7:0] ADDR_CTL = 8'hFF;

  localparam int CTL_RELOAD_BIT = 0;
  localparam int CTL_BURN_BIT   = 2;
  localparam int CTL_FIXED_BIT  = 3;
  localparam int CTL_DONE_BIT   = 4;

  typedef enum logic [2:0] {
    LNK_IDLE,
    LNK_ADDR,
    LNK_REG,
    LNK_DATA,
    LNK_TX,
    LNK_SKIP
  } link_state_t;
endpackage

// File: rtl/trim_i2c_link.sv
module trim_i2c_link
  import trim_otp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_s, sda_s, scl_q, sda_q;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
          sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[LAST];
  assign sda_s = sda_pipe[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  logic scl_rise, scl_fall, bus_start, bus_stop;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  link_state_t state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, ptr, txbyte;
  logic        dir_rd, mack, pull;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LNK_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ptr     <= '0;
      txbyte  <= '0;
      dir_rd  <= 1'b0;
      mack    <= 1'b0;
      pull    <= 1'b0;
      wr_en_o <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (bus_start) begin
        state  <= LNK_ADDR;
        bitcnt <= '0;
        pull   <= 1'b0;
      end else if (bus_stop) begin
        state <= LNK_IDLE;
        pull  <= 1'b0;
      end else if (scl_rise && state != LNK_IDLE && state != LNK_SKIP) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (state == LNK_DATA) wr_en_o <= 1'b1;
          if (state == LNK_TX) mack <= ~sda_s;
        end
      end else if (scl_fall) begin
        case (state)
          LNK_ADDR: begin
            if (bitcnt == 4'd8) begin
              if (shreg[7:1] == DEV_ADDR) begin
                pull   <= 1'b1;
                dir_rd <= shreg[0];
              end else begin
                state <= LNK_SKIP;
              end
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (dir_rd) begin
                state  <= LNK_TX;
                txbyte <= rd_data_i;
                pull   <= ~rd_data_i[7];
              end else begin
                state <= LNK_REG;
                pull  <= 1'b0;
              end
            end
          end
          LNK_REG: begin
            if (bitcnt == 4'd8) begin
              pull <= 1'b1;
              ptr  <= shreg;
            end else if (bitcnt == 4'd9) begin
              pull   <= 1'b0;
              bitcnt <= '0;
              state  <= LNK_DATA;
            end
          end
          LNK_DATA: begin
            if (bitcnt == 4'd8) begin
              pull <= 1'b1;
            end else if (bitcnt == 4'd9) begin
              pull  <= 1'b0;
              state <= LNK_SKIP;
            end
          end
          LNK_TX: begin
            if (bitcnt == 4'd8) begin
              pull <= 1'b0;
            end else if (bitcnt == 4'd9) begin
              if (mack) begin
                txbyte <= rd_data_i;
                pull   <= ~rd_data_i[7];
                bitcnt <= '0;
              end else begin
                state <= LNK_SKIP;
              end
            end else begin
              pull <= ~txbyte[3'd7 - bitcnt[2:0]];
            end
          end
          default: pull <= 1'b0;
        endcase
      end
    end
  end

  assign sda_pull_o = pull;
  assign wr_addr_o  = ptr;
  assign wr_data_o  = shreg;
  assign rd_addr_o  = ptr;

  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  p_quiet_unaddressed_r2: assert property (@(posedge clk) disable iff (rst)
    (state == LNK_SKIP || state == LNK_IDLE) |-> !sda_pull_o);
endmodule

// File: rtl/trim_regs.sv
module trim_regs
  import trim_otp_pkg::*;
#(
  parameter int               SW_W    = 6,
  parameter int               LIN_W   = 4,
  parameter logic [SW_W-1:0]  SW_RST  = 6'h1F,
  parameter logic [LIN_W-1:0] LIN_RST = 4'h7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic             load_en,
  input  logic [SW_W-1:0]  otp_sw,
  input  logic [LIN_W-1:0] otp_lin,
  input  logic             otp_burned,
  output logic [SW_W-1:0]  sw_trim,
  output logic [LIN_W-1:0] lin_trim,
  output logic             burn_bit,
  output logic             reload_req
);
  logic burned;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_trim    <= SW_RST;
      lin_trim   <= LIN_RST;
      burned     <= 1'b0;
      burn_bit   <= 1'b0;
      reload_req <= 1'b0;
    end else begin
      reload_req <= 1'b0;
      if (load_en) begin
        sw_trim  <= otp_sw;
        lin_trim <= otp_lin;
        burned   <= otp_burned;
      end else if (wr_en && wr_addr == ADDR_SW) begin
        sw_trim <= wr_data[SW_W-1:0];
      end else if (wr_en && wr_addr == ADDR_LIN) begin
        lin_trim <= wr_data[LIN_W-1:0];
      end
      if (wr_en && wr_addr == ADDR_CTL) begin
        burn_bit   <= wr_data[CTL_BURN_BIT];
        reload_req <= wr_data[CTL_RELOAD_BIT];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (rd_addr)
      ADDR_SW:  rd_data = {{(8-SW_W){1'b0}}, sw_trim};
      ADDR_LIN: rd_data = {{(8-LIN_W){1'b0}}, lin_trim};
      ADDR_CTL: begin
        rd_data[CTL_DONE_BIT]  = burned;
        rd_data[CTL_FIXED_BIT] = 1'b1;
        rd_data[CTL_BURN_BIT]  = burn_bit;
      end
      default: rd_data = 8'h00;
    endcase
  end

  p_done_after_load_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(burned) |-> $past(load_en));

  p_load_copies_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (sw_trim == $past(otp_sw)) && (lin_trim == $past(otp_lin)));
endmodule

// File: rtl/trim_otp_seq.sv
module trim_otp_seq #(
  parameter int               SW_W         = 6,
  parameter int               LIN_W        = 4,
  parameter logic [SW_W-1:0]  SW_RST       = 6'h1F,
  parameter logic [LIN_W-1:0] LIN_RST      = 4'h7,
  parameter int               RELOAD_TICKS = 25,
  parameter int               BURN_TICKS   = 12500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             por,
  input  logic             reload_req,
  input  logic             burn_bit,
  input  logic [SW_W-1:0]  sw_trim,
  input  logic [LIN_W-1:0] lin_trim,
  output logic             load_en,
  output logic [SW_W-1:0]  otp_sw,
  output logic [LIN_W-1:0] otp_lin,
  output logic             otp_burned,
  output logic             osc_en
);
  localparam int RCW = $clog2(RELOAD_TICKS + 1);
  localparam int HCW = $clog2(BURN_TICKS + 1);
  localparam logic [RCW-1:0] R_LAST = RCW'(RELOAD_TICKS - 1);
  localparam logic [HCW-1:0] H_FULL = HCW'(BURN_TICKS);

  logic           busy, busy_nxt, finish;
  logic [RCW-1:0] rcnt;
  logic [HCW-1:0] hold;
  logic           burn_q;

  assign finish   = busy && tick && (rcnt == R_LAST);
  assign busy_nxt = por || reload_req || (busy && !finish);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      rcnt    <= '0;
      load_en <= 1'b0;
      osc_en  <= 1'b0;
    end else begin
      load_en <= finish && !(por || reload_req);
      busy    <= busy_nxt;
      osc_en  <= busy_nxt || burn_bit;
      if (por || reload_req) rcnt <= '0;
      else if (busy && tick && !finish) rcnt <= rcnt + RCW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      burn_q     <= 1'b0;
      otp_sw     <= SW_RST;
      otp_lin    <= LIN_RST;
      otp_burned <= 1'b0;
    end else begin
      burn_q <= burn_bit;
      if (!burn_bit) hold <= '0;
      else if (tick && hold != H_FULL) hold <= hold + HCW'(1);
      if (burn_q && !burn_bit && hold == H_FULL && !otp_burned) begin
        otp_sw     <= sw_trim;
        otp_lin    <= lin_trim;
        otp_burned <= 1'b1;
      end
    end
  end

  p_otp_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    otp_burned |=> otp_burned && $stable(otp_sw) && $stable(otp_lin));

  p_burn_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(otp_burned) |-> !$past(burn_bit) && $past(burn_bit, 2));

  p_load_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    load_en |=> !load_en);
endmodule

// File: rtl/trim_otp_i2c.sv
module trim_otp_i2c #(
  parameter int               SYNC_STAGES  = 2,
  parameter int               SW_W         = 6,
  parameter int               LIN_W        = 4,
  parameter logic [SW_W-1:0]  SW_RST       = 6'h1F,
  parameter logic [LIN_W-1:0] LIN_RST      = 4'h7,
  parameter int               RELOAD_TICKS = 25,
  parameter int               BURN_TICKS   = 12500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic             por_i,
  input  logic             tick_i,
  output logic [SW_W-1:0]  sw_trim_o,
  output logic [LIN_W-1:0] lin_trim_o,
  output logic             osc_en_o,
  output logic             burn_en_o
);
  logic             wr_en, load_en, otp_burned, burn_bit, reload_req;
  logic [7:0]       wr_addr, wr_data, rd_addr, rd_data;
  logic [SW_W-1:0]  otp_sw;
  logic [LIN_W-1:0] otp_lin;

  trim_i2c_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  trim_regs #(.SW_W(SW_W), .LIN_W(LIN_W), .SW_RST(SW_RST), .LIN_RST(LIN_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .load_en(load_en), .otp_sw(otp_sw),
    .otp_lin(otp_lin), .otp_burned(otp_burned), .sw_trim(sw_trim_o),
    .lin_trim(lin_trim_o), .burn_bit(burn_bit), .reload_req(reload_req)
  );

  trim_otp_seq #(.SW_W(SW_W), .LIN_W(LIN_W), .SW_RST(SW_RST), .LIN_RST(LIN_RST),
                 .RELOAD_TICKS(RELOAD_TICKS), .BURN_TICKS(BURN_TICKS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick_i), .por(por_i), .reload_req(reload_req),
    .burn_bit(burn_bit), .sw_trim(sw_trim_o), .lin_trim(lin_trim_o),
    .load_en(load_en), .otp_sw(otp_sw), .otp_lin(otp_lin),
    .otp_burned(otp_burned), .osc_en(osc_en_o)
  );

  assign burn_en_o = burn_bit;
endmodule

// File: tb/test_trim_otp_i2c.sv
module test_trim_otp_i2c;
  localparam int H      = 16;
  localparam int TDIV   = 4;
  localparam int RTICKS = 25;
  localparam int BTICKS = 600;

  logic clk = 0, rst = 1, por = 0, tick = 0;
  logic m_scl = 1, m_sda = 1;
  logic sda_pull;
  logic [5:0] sw_trim;
  logic [3:0] lin_trim;
  logic osc_en, burn_en;
  wire  sda_bus = m_sda & ~sda_pull;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t       exp_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;

  trim_otp_i2c #(.RELOAD_TICKS(RTICKS), .BURN_TICKS(BTICKS)) i_trim_otp_i2c (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .por_i(por), .tick_i(tick), .sw_trim_o(sw_trim), .lin_trim_o(lin_trim),
    .osc_en_o(osc_en), .burn_en_o(burn_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tick = (tc == 0);
      tc = (tc + 1) % TDIV;
    end
  end

  initial begin
    forever begin
      logic [7:0] a;
      exp_t e;
      wait (act_q.size() != 0);
      a = act_q.pop_front();
      if (exp_q.size() == 0) check("scoreboard underflow", a, 32'hFFFF_FFFF);
      else begin
        e = exp_q.pop_front();
        check(e.tag, a, e.v);
      end
    end
  end

  task automatic bus_start();
    m_sda = 1; wait_clk(H); m_scl = 1; wait_clk(H); m_sda = 0; wait_clk(H); m_scl = 0; wait_clk(H);
  endtask

  task automatic bus_stop();
    m_sda = 0; wait_clk(H); m_scl = 1; wait_clk(H); m_sda = 1; wait_clk(H);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wait_clk(H); m_scl = 1; wait_clk(H); m_scl = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1; wait_clk(H); m_scl = 1; wait_clk(H/2);
    ack = ~sda_bus; wait_clk(H/2); m_scl = 0;
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; wait_clk(H); m_scl = 1; wait_clk(H/2);
      b[i] = sda_bus; wait_clk(H/2); m_scl = 0;
    end
    put_bit(1'b1);
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                        output int acks);
    logic a;
    acks = 0;
    bus_start();
    put_byte({dev, 1'b0}, a);
    if (a) begin
      acks++;
      put_byte(ra, a); if (a) acks++;
      put_byte(d, a);  if (a) acks++;
    end
    bus_stop();
  endtask

  task automatic wr(input logic [7:0] ra, input logic [7:0] d);
    int acks;
    wr_reg(7'h28, ra, d, acks);
  endtask

  task automatic rd_reg(input logic [7:0] ra, input logic [7:0] exp, input string tag);
    logic a;
    logic [7:0] v;
    exp_q.push_back('{v: exp, tag: tag});
    bus_start();
    put_byte(8'h50, a);
    put_byte(ra, a);
    bus_start();
    put_byte(8'h51, a);
    get_byte(v);
    bus_stop();
    act_q.push_back(v);
  endtask

  initial begin
    wait_clk(190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog (all R) actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int acks, dur;
    wait_clk(5); rst = 0; wait_clk(5);
    // R1 reset state
    check("R1 sw trim", sw_trim, 6'h1F);
    check("R1 lin trim", lin_trim, 4'h7);
    check("R1 osc_en", osc_en, 0);
    check("R1 burn_en", burn_en, 0);
    check("R1 sda pull", sda_pull, 0);
    rd_reg(8'hFF, 8'h08, "R1 R8 ctl reset");

    // R3 R5 write of switching trim, upper bits dropped
    wr_reg(7'h28, 8'h01, 8'hEA, acks);
    check("R3 three acks", acks, 3);
    check("R5 sw trim out", sw_trim, 6'h2A);
    rd_reg(8'h01, 8'h2A, "R4 R5 sw readback");
    wr(8'h02, 8'hF5);
    check("R5 lin trim out", lin_trim, 4'h5);
    rd_reg(8'h02, 8'h05, "R4 R5 lin readback");

    // R2 foreign address
    wr_reg(7'h29, 8'h01, 8'h11, acks);
    check("R2 no ack foreign", acks, 0);
    check("R2 sw unchanged", sw_trim, 6'h2A);

    // R6 unmapped register
    wr_reg(7'h28, 8'h10, 8'h55, acks);
    check("R6 acked", acks, 3);
    rd_reg(8'h10, 8'h00, "R6 unmapped reads 0");
    check("R6 sw unchanged", sw_trim, 6'h2A);
    check("R6 lin unchanged", lin_trim, 4'h5);

    // R7 stop mid data byte
    begin
      logic a;
      bus_start(); put_byte(8'h50, a); put_byte(8'h01, a);
      put_bit(0); put_bit(0); put_bit(0); put_bit(1);
      bus_stop();
      check("R7 stop abort", sw_trim, 6'h2A);
      // R7 repeated start mid data byte
      bus_start(); put_byte(8'h50, a); put_byte(8'h02, a);
      put_bit(1); put_bit(1); put_bit(0);
      bus_start(); bus_stop();
      check("R7 restart abort", lin_trim, 4'h5);
    end

    // R9 reload by control bit, blank store
    wr(8'hFF, 8'h01);
    check("R9 osc during reload", osc_en, 1);
    wait_clk(RTICKS*TDIV + 50);
    check("R9 osc off", osc_en, 0);
    check("R9 sw blank", sw_trim, 6'h1F);
    check("R9 lin blank", lin_trim, 4'h7);
    rd_reg(8'hFF, 8'h08, "R8 reload bit reads 0");

    // R10 short hold: nothing stored
    wr(8'h01, 8'h15); wr(8'h02, 8'h0A);
    wr(8'hFF, 8'h04);
    check("R8 burn_en follows", burn_en, 1);
    check("R10 osc during burn", osc_en, 1);
    rd_reg(8'hFF, 8'h0C, "R8 burn bit readback");
    wr(8'hFF, 8'h00);
    check("R8 burn_en cleared", burn_en, 0);
    wr(8'hFF, 8'h01);
    wait_clk(RTICKS*TDIV + 50);
    check("R10 short hold stores nothing", sw_trim, 6'h1F);
    rd_reg(8'hFF, 8'h08, "R10 not burned");

    // R10 R11 long hold
    wr(8'h01, 8'h15); wr(8'h02, 8'h0A);
    wr(8'hFF, 8'h04);
    wait_clk(3000);
    wr(8'hFF, 8'h00);
    rd_reg(8'hFF, 8'h08, "R11 marker waits for reload");
    wr(8'h01, 8'h01); wr(8'h02, 8'h00);
    @(negedge clk); por = 1; @(negedge clk); por = 0;
    dur = 0;
    while (!osc_en && dur < 10) begin @(negedge clk); dur++; end
    dur = 0;
    while (osc_en && dur < 1000) begin @(negedge clk); dur++; end
    check("R9 reload length ok", (dur >= RTICKS*TDIV - 6 && dur <= RTICKS*TDIV + 6), 1);
    wait_clk(4);
    check("R10 sw from store", sw_trim, 6'h15);
    check("R10 lin from store", lin_trim, 4'hA);
    rd_reg(8'hFF, 8'h18, "R11 marker after reload");

    // R12 second burn ignored
    wr(8'h01, 8'h33); wr(8'h02, 8'h01);
    wr(8'hFF, 8'h04);
    wait_clk(3000);
    wr(8'hFF, 8'h00);
    wr(8'hFF, 8'h01);
    wait_clk(RTICKS*TDIV + 50);
    check("R12 sw frozen", sw_trim, 6'h15);
    check("R12 lin frozen", lin_trim, 4'hA);

    wait (act_q.size() == 0);
    wait_clk(5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule